// File: doc/BRIEF.md
# Serial Register Access Port (two-wire slave)

This block is a two-wire serial bus slave that lets a host controller read and write a bank of byte-wide control registers. The registers themselves live outside the block. The port presents a register address, a write-data byte and a one-cycle write strobe, and it takes back a read-data byte for whatever address it currently presents. The bus data line is open drain. The block never drives it high; it only asserts an enable that pulls the line low.

The slave answers to a 7-bit device address. The upper five bits of that address are fixed, and the lowest two come from strap pins, so up to four of these ports can share one bus. After the device address, a write transaction carries a pointer byte. The pointer byte chooses the register and says whether the pointer advances after each data byte. Any bytes after it are register data. A read transaction streams out registers starting at the current pointer. A common pattern is a pointer-only write followed by a repeated START and a read.

Both bus lines are resynchronised into the system clock domain. START and STOP are recognised from data-line edges while the clock line is high. A synchronous active-high reset returns the port to idle with the pointer at zero and auto-increment off.

Top module: `i2c_reg_port`

## Requirements
- R1: The slave acknowledges an address byte whose bits 7:3 are 10011 and bits 2:1 equal strap_i[1:0]. Bit 0 of that byte is the direction (1 = read). It acknowledges by pulling SDA low during the ninth clock of the byte.
- R2: An address byte that does not match gets no acknowledge. Until the next START or STOP the slave then drives SDA never and issues no write strobe.
- R3: The first byte after a matching write address is the pointer byte: bit 7 is the auto-increment flag and bits 6:0 are the register address. The slave acknowledges it.
- R4: Each later data byte in a write produces exactly one reg_we pulse of one clock. During that pulse reg_addr equals the pointer and reg_wdata equals the byte. The byte is acknowledged.
- R5: With auto-increment set, the pointer advances by one after each written or transmitted byte, wrapping from 127 to 0.
- R6: With auto-increment clear, the pointer stays fixed, so repeated data bytes all target one register.
- R7: In a read, the slave shifts out the register at the pointer, MSB first. Each master ACK makes it send the next byte.
- R8: After a master NACK on a read byte, the slave releases SDA and stays off the bus until the next START or STOP.
- R9: A write carrying only the pointer byte sets the pointer, and a later read transaction starts from it.
- R10: A START (SDA falling while SCL is high) restarts the address phase at any point, even in the middle of a byte. A STOP (SDA rising while SCL is high) returns the slave to idle with SDA released.
- R11: Reset sets the pointer to 0, clears auto-increment, releases SDA and suppresses the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 2 | Strap value for the two low device-address bits |
| sda_oe | output | 1 | When high, pulls the data line low |
| reg_addr | output | 7 | Current register pointer |
| reg_wdata | output | 8 | Byte to write into the register bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Contents of the register at reg_addr |

## Verification
The embedded assertions check the following on every cycle:
- the write strobe lasts one cycle;
- the pointer moves after a strobe only when auto-increment is set;
- the slave stays off the bus while idle or ignoring a transaction;
- a START always returns the controller to the address phase;
- reset clears the pointer.

The bench's bus scenarios are what show the rest: the address match against the strap pins, the byte order on the wire, the continuation of a read on master ACK, pointer wrap, a pointer-only write followed by a read, and recovery from a START in the middle of a byte.

// File: rtl/i2c_port_pkg.sv
package i2c_port_pkg;

    localparam int REG_AW = 7;
    localparam int DW     = 8;
    localparam int BIT_CW = $clog2(DW + 1);

    localparam logic [4:0] DEV_ID_HI = 5'b10011;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_MAP,
        ST_MAP_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } port_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic              auto_inc;
        logic [REG_AW-1:0] addr;
    } map_t;

    function automatic logic dev_match(input logic [DW-1:0] b, input logic [1:0] strap);
        return (b[7:3] == DEV_ID_HI) && (b[2:1] == strap);
    endfunction

    function automatic logic is_rx_state(input port_state_e s);
        return (s == ST_ADDR) || (s == ST_MAP) || (s == ST_WDATA);
    endfunction

    function automatic logic is_ack_state(input port_state_e s);
        return (s == ST_ADDR_ACK) || (s == ST_MAP_ACK) || (s == ST_WDATA_ACK);
    endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
    import i2c_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    localparam int DEPTH = (SYNC_STAGES < 2) ? 3 : SYNC_STAGES + 1;

    logic [DEPTH-1:0] scl_q;
    logic [DEPTH-1:0] sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[DEPTH-2:0], scl_i};
            sda_q <= {sda_q[DEPTH-2:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;

    always_comb begin
        scl_now = scl_q[DEPTH-2];
        scl_old = scl_q[DEPTH-1];
        sda_now = sda_q[DEPTH-2];
        sda_old = sda_q[DEPTH-1];

        evt.scl_rise = scl_now & ~scl_old;
        evt.scl_fall = ~scl_now & scl_old;
        evt.start    = scl_now & scl_old & sda_old & ~sda_now;
        evt.stop     = scl_now & scl_old & ~sda_old & sda_now;
        evt.sda      = sda_now;
    end

endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift
    import i2c_port_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_en,
    input  logic          sda_in,
    input  logic          tx_load,
    input  logic [DW-1:0] tx_val,
    input  logic          tx_shift,
    output logic [DW-1:0] rx_byte,
    output logic          tx_bit
);

    logic [DW-1:0] tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte <= '0;
        end else if (rx_en) begin
            rx_byte <= {rx_byte[DW-2:0], sda_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '1;
        end else if (tx_load) begin
            tx_q <= tx_val;
        end else if (tx_shift) begin
            tx_q <= {tx_q[DW-2:0], 1'b1};
        end
    end

    assign tx_bit = tx_q[DW-1];

endmodule

// File: rtl/i2c_map_ptr.sv
module i2c_map_ptr
    import i2c_port_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  map_t load_val,
    input  logic step,
    output map_t cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_val;
        end else if (step && cur.auto_inc) begin
            cur.addr <= cur.addr + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port
    import i2c_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    output logic              sda_oe,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DW-1:0]     reg_wdata,
    output logic              reg_we,
    input  logic [DW-1:0]     reg_rdata
);

    bus_evt_t      evt;
    port_state_e   state;
    logic [BIT_CW-1:0] bcnt;
    logic          is_read;
    logic          rack_ok;
    logic [DW-1:0] rx_byte;
    logic          tx_bit;
    map_t          map_cur;

    logic rx_en, byte_done, map_load, ptr_step, tx_load, tx_shift, last_tx_bit;

    i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    always_comb begin
        rx_en       = evt.scl_rise && is_rx_state(state);
        byte_done   = evt.scl_fall && (bcnt == BIT_CW'(DW)) && is_rx_state(state);
        map_load    = byte_done && (state == ST_MAP);
        reg_we      = byte_done && (state == ST_WDATA);
        last_tx_bit = (state == ST_RDATA) && evt.scl_fall && (bcnt == BIT_CW'(DW - 1));
        ptr_step    = reg_we || last_tx_bit;
        tx_load     = evt.scl_fall &&
                      (((state == ST_ADDR_ACK) && is_read) || ((state == ST_RACK) && rack_ok));
        tx_shift    = (state == ST_RDATA) && evt.scl_fall && !last_tx_bit;
        sda_oe      = is_ack_state(state) || ((state == ST_RDATA) && !tx_bit);
    end

    i2c_byte_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .rx_en    (rx_en),
        .sda_in   (evt.sda),
        .tx_load  (tx_load),
        .tx_val   (reg_rdata),
        .tx_shift (tx_shift),
        .rx_byte  (rx_byte),
        .tx_bit   (tx_bit)
    );

    i2c_map_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (map_load),
        .load_val (map_t'(rx_byte)),
        .step     (ptr_step),
        .cur      (map_cur)
    );

    assign reg_addr  = map_cur.addr;
    assign reg_wdata = rx_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bcnt    <= '0;
            is_read <= 1'b0;
            rack_ok <= 1'b0;
        end else if (evt.start) begin
            state <= ST_ADDR;
            bcnt  <= '0;
        end else if (evt.stop) begin
            state <= ST_IDLE;
            bcnt  <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_MAP, ST_WDATA: begin
                    if (evt.scl_rise) begin
                        bcnt <= bcnt + 1'b1;
                    end else if (byte_done) begin
                        bcnt <= '0;
                        if (state == ST_ADDR) begin
                            if (dev_match(rx_byte, strap_i)) begin
                                state   <= ST_ADDR_ACK;
                                is_read <= rx_byte[0];
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else if (state == ST_MAP) begin
                            state <= ST_MAP_ACK;
                        end else begin
                            state <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.scl_fall) begin
                        bcnt  <= '0;
                        state <= is_read ? ST_RDATA : ST_MAP;
                    end
                end
                ST_MAP_ACK, ST_WDATA_ACK: begin
                    if (evt.scl_fall) begin
                        bcnt  <= '0;
                        state <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (last_tx_bit) begin
                        bcnt  <= '0;
                        state <= ST_RACK;
                    end else if (evt.scl_fall) begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                ST_RACK: begin
                    if (evt.scl_rise) begin
                        rack_ok <= ~evt.sda;
                    end else if (evt.scl_fall) begin
                        bcnt  <= '0;
                        state <= rack_ok ? ST_RDATA : ST_IGNORE;
                    end
                end
                ST_IGNORE: state <= ST_IGNORE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);                                             // R4
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (reg_we && map_cur.auto_inc) |=> (reg_addr == $past(reg_addr) + 7'd1)); // R5
    AST_PTR_FIXED: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !map_cur.auto_inc) |=> (reg_addr == $past(reg_addr))); // R6
    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> (!sda_oe && !reg_we));                   // R2
    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);                                  // R10
    AST_START_RESTART: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_ADDR));                                // R10
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (reg_addr == '0 && !map_cur.auto_inc && !sda_oe && !reg_we)); // R11

endmodule

// File: tb/sim_i2c_reg_port.sv
module sim_i2c_reg_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       sda_bus;
    logic       sda_oe;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_reg_port u0 (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .strap_i   (strap),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    // external register bank model
    logic [7:0] regs [128];
    logic       booted = 1'b0;
    int         we_cnt = 0;
    int         oe_cnt = 0;

    always @(posedge clk) begin
        if (rst && !booted) begin
            for (int i = 0; i < 128; i++) regs[i] <= 8'h00;
        end else if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
        end
        if (reg_we) we_cnt <= we_cnt + 1;
        if (sda_oe) oe_cnt <= oe_cnt + 1;
    end

    assign reg_rdata = regs[reg_addr];

    int         checks = 0;
    int         errors = 0;
    logic [7:0] exp_m [128];
    logic [6:0] cur_ptr = 7'd0;
    logic       cur_ai  = 1'b0;
    bit         done = 1'b0;

    localparam logic [7:0] WADDR = 8'h9C;  // 10011 10 0
    localparam logic [7:0] RADDR = 8'h9D;  // 10011 10 1

    // {auto_inc, reg address, data}
    localparam logic [15:0] VEC [6] = '{
        16'h005A, 16'h0733, 16'h2AC4, 16'h7F81, 16'h40FF, 16'h1100
    };

    task automatic q();
        repeat (10) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
    endtask

    task automatic clk_bit(input logic b);
        sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) clk_bit(b[i]);
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = sda_bus; q(); scl_m = 1'b0; q();
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q(); scl_m = 1'b1; q(); b[i] = sda_bus; q(); scl_m = 1'b0; q();
        end
        sda_m = ~m_ack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
        sda_m = 1'b1;
    endtask

    // write transaction: address, pointer byte, n data bytes (n may be 0)
    task automatic wr_burst(input logic ai, input logic [6:0] a,
                            input logic [31:0] pk, input int n);
        logic ack;
        i2c_start();
        send_byte(WADDR, ack); chk("R1 write address ack", ack, 1'b0);
        send_byte({ai, a}, ack); chk("R3 pointer byte ack", ack, 1'b0);
        cur_ptr = a; cur_ai = ai;
        for (int k = 0; k < n; k++) begin
            send_byte(pk[8*k +: 8], ack); chk("R4 data byte ack", ack, 1'b0);
            exp_m[cur_ptr] = pk[8*k +: 8];
            if (cur_ai) cur_ptr = cur_ptr + 7'd1;
        end
        i2c_stop();
    endtask

    // read n bytes from the current pointer; last byte NACKed
    task automatic rd_cur(input int n, input string tag);
        logic ack;
        logic [7:0] b;
        i2c_start();
        send_byte(RADDR, ack); chk("R1 read address ack", ack, 1'b0);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            chk(tag, b, exp_m[cur_ptr]);
            if (cur_ai) cur_ptr = cur_ptr + 7'd1;
        end
        i2c_stop();
    endtask

    initial begin
        logic ack;
        logic [7:0] b;
        int w0;
        for (int i = 0; i < 128; i++) exp_m[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0; booted = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset pointer", reg_addr, 7'd0);
        chk("R11 reset sda released", sda_oe, 1'b0);
        chk("R11 reset no strobe", reg_we, 1'b0);

        // table of single writes then pointer-set read-back (R4 R9)
        for (int v = 0; v < 6; v++) begin
            wr_burst(VEC[v][15], VEC[v][14:8], {24'h0, VEC[v][7:0]}, 1);
            wr_burst(1'b0, VEC[v][14:8], 32'h0, 0);
            rd_cur(1, "R9 read back after pointer-only write");
        end

        // R5 auto-increment burst write and burst read, with R7 continuation
        wr_burst(1'b1, 7'h10, 32'h00C3B2A1, 3);
        wr_burst(1'b1, 7'h10, 32'h0, 0);
        rd_cur(3, "R7 R5 burst read");
        chk("R5 pointer after burst read", reg_addr, 7'h13);

        // R5 wrap from 127 to 0
        wr_burst(1'b1, 7'h7F, 32'h0000E7D6, 2);
        chk("R5 wrap write at 7F", regs[7'h7F], 8'hD6);
        chk("R5 wrap write at 00", regs[7'h00], 8'hE7);

        // R6 fixed pointer: repeated bytes hit one register
        wr_burst(1'b0, 7'h20, 32'h00003E2D, 2);
        chk("R6 fixed pointer last value", regs[7'h20], 8'h3E);
        chk("R6 neighbour untouched", regs[7'h21], 8'h00);
        chk("R6 pointer held", reg_addr, 7'h20);
        rd_cur(2, "R6 repeated read of fixed pointer");

        // R2 address mismatch (wrong strap bits) on write and read
        w0 = we_cnt;
        @(negedge clk); oe_cnt = 0;
        i2c_start();
        send_byte(8'h98, ack); chk("R2 mismatch write no ack", ack, 1'b1);
        send_byte(8'h05, ack); chk("R2 ignored byte no ack", ack, 1'b1);
        send_byte(8'h77, ack); chk("R2 ignored byte no ack", ack, 1'b1);
        i2c_stop();
        chk("R2 no write strobe", we_cnt, w0);
        chk("R2 SDA never driven", oe_cnt, 0);
        chk("R2 register untouched", regs[7'h05], 8'h00);
        i2c_start();
        send_byte(8'h9B, ack); chk("R2 mismatch read no ack", ack, 1'b1);
        i2c_stop();

        // R8 master NACK then slave stays off the bus
        wr_burst(1'b0, 7'h07, 32'h0, 0);
        i2c_start();
        send_byte(RADDR, ack); chk("R1 read address ack", ack, 1'b0);
        recv_byte(1'b0, b); chk("R7 single read", b, exp_m[7'h07]);
        @(negedge clk); oe_cnt = 0;
        send_byte(8'hFF, ack);
        chk("R8 SDA released after NACK", oe_cnt, 0);
        chk("R8 no ack after NACK", ack, 1'b1);
        i2c_stop();

        // R10 START in the middle of a byte restarts the address phase
        i2c_start();
        send_byte(WADDR, ack);
        clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b1);
        i2c_start();
        send_byte(RADDR, ack); chk("R10 restart read address ack", ack, 1'b0);
        recv_byte(1'b0, b); chk("R10 read after mid-byte START", b, exp_m[7'h07]);
        i2c_stop();
        @(negedge clk);
        chk("R10 SDA released after STOP", sda_oe, 1'b0);

        // R11 reset clears pointer and auto-increment
        wr_burst(1'b1, 7'h33, 32'h0, 0);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R11 pointer cleared by reset", reg_addr, 7'd0);
        cur_ptr = 7'd0; cur_ai = 1'b0;
        rd_cur(2, "R11 auto-increment off after reset");
        chk("R11 pointer still zero", reg_addr, 7'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule